// File: doc/BRIEF.md
# Balanced Ternary Logic Unit

This unit operates on words of signed ternary digits. Each digit is one of −1, 0 or +1 and is carried on two wires. A word holds `N_TRITS` digits, five by default, which covers the integers −121 to +121. Digit 0 is the least significant and sits in bits [1:0]. Digit k sits in bits [2k+1:2k].

The unit offers six operations:

- per-digit negation
- per-digit minimum of two operands
- per-digit maximum of three operands
- per-digit median (majority) of three operands
- signed addition, with a carry trit out of the top digit
- signed subtraction, with a carry trit out of the top digit

A caller presents three operand words, an operation code and a valid strobe. The unit captures the result word, a zero flag, the carry trit and an error flag on the next rising clock edge. A branch-on-zero decision can take the zero flag directly.

Negative values need no special form. Subtraction adds the digit-wise negation of the subtrahend, and carries between digits are themselves signed trits.

Top module: `bt_logic_unit`

## Requirements
- R1: Digit codes are 2'b00 = 0, 2'b01 = +1 and 2'b11 = −1. If any digit of A, B or C holds 2'b10, the error flag is set in the registered result, and that digit is used as 0. No output digit ever holds 2'b10.
- R2: Operation code 0 gives the digit-wise negation of A: +1 becomes −1, −1 becomes +1 and 0 stays 0.
- R3: Operation code 1 gives, in each digit, the smaller of the A and B digits.
- R4: Operation code 2 gives, in each digit, the largest of the A, B and C digits.
- R5: Operation code 3 gives, in each digit, the middle value of the A, B and C digits. This holds for all 27 digit combinations.
- R6: Operation code 4 gives the sum A+B. The result word and the carry trit satisfy value(result) + 3^N_TRITS × carry = value(A) + value(B). Carry is 0 for operation codes other than 4 and 5.
- R7: Operation code 5 gives the difference A−B. The result word and the carry trit satisfy value(result) + 3^N_TRITS × carry = value(A) − value(B). A non-zero carry marks overflow.
- R8: The zero flag is 1 exactly when every digit of the registered result is 0. For example, (+1) + (−1) sets it.
- R9: Operation codes 6 and 7 give an all-zero result word, zero flag 1, carry 0 and error flag 1.
- R10: All outputs change only on a clock edge where the valid strobe is high. That edge captures the result of the inputs present at it. While the strobe is low, the outputs hold.
- R11: A synchronous active-high reset clears the result word, carry, zero flag and error flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Capture strobe for the operands and operation code |
| op_sel | input | 3 | Operation code (0 NEG, 1 MIN, 2 MAX, 3 MED, 4 ADD, 5 SUB) |
| opnd_a | input | 2*N_TRITS | Operand A, two bits per digit |
| opnd_b | input | 2*N_TRITS | Operand B |
| opnd_c | input | 2*N_TRITS | Operand C, used by MAX and MED |
| res_word | output | 2*N_TRITS | Registered result word |
| res_zero | output | 1 | Result word is all zero digits |
| res_carry | output | 2 | Carry trit out of the top digit |
| res_err | output | 1 | Illegal digit code on an operand, or an undefined operation code |

## Verification
Both arithmetic operations are swept over every pair of 5-digit operands and compared with integer arithmetic, which exercises carry chains of every length and wrap-around in both directions. A wrong digit/carry split in one adder cell would give a result off by a multiple of a power of three, or a carry trit with the wrong sign at the range edges. The median is checked on all 27 digit triples. A min/max-based median with a wrong nesting would return an extreme value, for example +1 instead of 0 for (−1, 0, +1). Other checks cover a word with one illegal digit code, the undefined operation codes, and a gap in the valid strobe. These would expose a unit that passes bad codes through, leaves the error flag clear, or updates its outputs without a strobe.

// File: rtl/bt_pkg.sv
package bt_pkg;

    typedef logic [1:0] trit_t;

    localparam trit_t T_ZERO = 2'b00;
    localparam trit_t T_POS  = 2'b01;
    localparam trit_t T_NEG  = 2'b11;
    localparam trit_t T_BAD  = 2'b10;

    typedef enum logic [2:0] {
        OP_NEG = 3'd0,
        OP_MIN = 3'd1,
        OP_MAX = 3'd2,
        OP_MED = 3'd3,
        OP_ADD = 3'd4,
        OP_SUB = 3'd5
    } op_e;

    // signed value of a digit or of a column sum, -3..+3
    typedef logic signed [2:0] tval_t;

    typedef struct packed {
        trit_t digit;
        trit_t carry;
    } fa_out_t;

    function automatic tval_t to_val(trit_t t);
        case (t)
            T_POS:   return 3'sd1;
            T_NEG:   return -3'sd1;
            default: return 3'sd0;
        endcase
    endfunction

    function automatic trit_t from_val(tval_t v);
        if (v > 3'sd0)      return T_POS;
        else if (v < 3'sd0) return T_NEG;
        else                return T_ZERO;
    endfunction

    function automatic trit_t neg_t(trit_t t);
        return from_val(-to_val(t));
    endfunction

    function automatic trit_t min_t(trit_t a, trit_t b);
        return (to_val(a) < to_val(b)) ? a : b;
    endfunction

    function automatic trit_t max_t(trit_t a, trit_t b);
        return (to_val(a) > to_val(b)) ? a : b;
    endfunction

    // middle value: the larger of min(a,b) and min(max(a,b),c)
    function automatic trit_t med_t(trit_t a, trit_t b, trit_t c);
        return max_t(min_t(a, b), min_t(max_t(a, b), c));
    endfunction

    // one balanced column: s = 3*carry + digit
    function automatic fa_out_t full_add(trit_t a, trit_t b, trit_t ci);
        tval_t   s;
        fa_out_t r;
        s = to_val(a) + to_val(b) + to_val(ci);
        if (s > 3'sd1) begin
            r.digit = from_val(s - 3'sd3);
            r.carry = T_POS;
        end else if (s < -3'sd1) begin
            r.digit = from_val(s + 3'sd3);
            r.carry = T_NEG;
        end else begin
            r.digit = from_val(s);
            r.carry = T_ZERO;
        end
        return r;
    endfunction

endpackage

// File: rtl/bt_sanitize.sv
module bt_sanitize
    import bt_pkg::*;
#(
    parameter int N_TRITS = 5
) (
    input  logic [2*N_TRITS-1:0] word_in,
    output logic [2*N_TRITS-1:0] word_out,
    output logic                 any_bad
);

    logic [N_TRITS-1:0] bad_dig;

    for (genvar gi = 0; gi < N_TRITS; gi++) begin : g_dig
        assign bad_dig[gi] = (word_in[2*gi +: 2] == T_BAD);
        assign word_out[2*gi +: 2] = bad_dig[gi] ? T_ZERO : word_in[2*gi +: 2];
    end

    assign any_bad = |bad_dig;

endmodule

// File: rtl/bt_digit_ops.sv
module bt_digit_ops
    import bt_pkg::*;
#(
    parameter int N_TRITS = 5
) (
    input  logic [2*N_TRITS-1:0] a_w,
    input  logic [2*N_TRITS-1:0] b_w,
    input  logic [2*N_TRITS-1:0] c_w,
    output logic [2*N_TRITS-1:0] neg_w,
    output logic [2*N_TRITS-1:0] min_w,
    output logic [2*N_TRITS-1:0] max_w,
    output logic [2*N_TRITS-1:0] med_w
);

    for (genvar gi = 0; gi < N_TRITS; gi++) begin : g_dig
        trit_t da, db, dc;
        assign da = a_w[2*gi +: 2];
        assign db = b_w[2*gi +: 2];
        assign dc = c_w[2*gi +: 2];
        assign neg_w[2*gi +: 2] = neg_t(da);
        assign min_w[2*gi +: 2] = min_t(da, db);
        assign max_w[2*gi +: 2] = max_t(max_t(da, db), dc);
        assign med_w[2*gi +: 2] = med_t(da, db, dc);
    end

endmodule

// File: rtl/bt_ripple_add.sv
module bt_ripple_add
    import bt_pkg::*;
#(
    parameter int N_TRITS = 5
) (
    input  logic [2*N_TRITS-1:0] a_w,
    input  logic [2*N_TRITS-1:0] b_w,
    input  trit_t                cin,
    output logic [2*N_TRITS-1:0] sum_w,
    output trit_t                cout
);

    trit_t chain [N_TRITS+1];

    assign chain[0] = cin;

    for (genvar gi = 0; gi < N_TRITS; gi++) begin : g_col
        fa_out_t fo;
        assign fo = full_add(a_w[2*gi +: 2], b_w[2*gi +: 2], chain[gi]);
        assign sum_w[2*gi +: 2] = fo.digit;
        assign chain[gi+1]      = fo.carry;
    end

    assign cout = chain[N_TRITS];

endmodule

// File: rtl/bt_logic_unit.sv
module bt_logic_unit
    import bt_pkg::*;
#(
    parameter int N_TRITS = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [2:0]           op_sel,
    input  logic [2*N_TRITS-1:0] opnd_a,
    input  logic [2*N_TRITS-1:0] opnd_b,
    input  logic [2*N_TRITS-1:0] opnd_c,
    output logic [2*N_TRITS-1:0] res_word,
    output logic                 res_zero,
    output logic [1:0]           res_carry,
    output logic                 res_err
);

    localparam int W = 2 * N_TRITS;

    logic [W-1:0] a_cl, b_cl, c_cl;
    logic         bad_a, bad_b, bad_c;

    bt_sanitize #(.N_TRITS(N_TRITS)) u_san_a (.word_in(opnd_a), .word_out(a_cl), .any_bad(bad_a));
    bt_sanitize #(.N_TRITS(N_TRITS)) u_san_b (.word_in(opnd_b), .word_out(b_cl), .any_bad(bad_b));
    bt_sanitize #(.N_TRITS(N_TRITS)) u_san_c (.word_in(opnd_c), .word_out(c_cl), .any_bad(bad_c));

    logic [W-1:0] neg_w, min_w, max_w, med_w;

    bt_digit_ops #(.N_TRITS(N_TRITS)) u_ops (
        .a_w   (a_cl),
        .b_w   (b_cl),
        .c_w   (c_cl),
        .neg_w (neg_w),
        .min_w (min_w),
        .max_w (max_w),
        .med_w (med_w)
    );

    // subtraction feeds the adder the digit-wise negation of B
    logic [W-1:0] b_neg, b_eff;
    for (genvar gi = 0; gi < N_TRITS; gi++) begin : g_bneg
        assign b_neg[2*gi +: 2] = neg_t(b_cl[2*gi +: 2]);
    end
    assign b_eff = (op_sel == OP_SUB) ? b_neg : b_cl;

    logic [W-1:0] sum_w;
    trit_t        sum_c;

    bt_ripple_add #(.N_TRITS(N_TRITS)) u_add (
        .a_w   (a_cl),
        .b_w   (b_eff),
        .cin   (T_ZERO),
        .sum_w (sum_w),
        .cout  (sum_c)
    );

    logic [W-1:0] nxt_word;
    trit_t        nxt_carry;
    logic         op_bad;

    always_comb begin
        nxt_word  = '0;
        nxt_carry = T_ZERO;
        op_bad    = 1'b0;
        case (op_sel)
            OP_NEG:  nxt_word = neg_w;
            OP_MIN:  nxt_word = min_w;
            OP_MAX:  nxt_word = max_w;
            OP_MED:  nxt_word = med_w;
            OP_ADD, OP_SUB: begin
                nxt_word  = sum_w;
                nxt_carry = sum_c;
            end
            default: op_bad = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_word  <= '0;
            res_zero  <= 1'b0;
            res_carry <= T_ZERO;
            res_err   <= 1'b0;
        end else if (in_valid) begin
            res_word  <= nxt_word;
            res_zero  <= (nxt_word == '0);
            res_carry <= nxt_carry;
            res_err   <= bad_a | bad_b | bad_c | op_bad;
        end
    end

    // output digits are never the illegal code
    logic out_has_bad;
    always_comb begin
        out_has_bad = 1'b0;
        for (int k = 0; k < N_TRITS; k++) begin
            if (res_word[2*k +: 2] == T_BAD) out_has_bad = 1'b1;
        end
    end

    a_r1_legal_out: assert property (@(posedge clk) disable iff (rst)
        !out_has_bad && res_carry != T_BAD);

    a_r9_bad_op: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_sel > 3'd5 |=> res_err && res_word == '0 && res_carry == T_ZERO);

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(res_word) && $stable(res_zero)
                      && $stable(res_carry) && $stable(res_err));

    a_r6_add_zero_identity: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_sel == OP_ADD && opnd_b == '0 && !bad_a
        |=> res_word == $past(opnd_a) && res_carry == T_ZERO);

    a_r2_neg_of_zero: assert property (@(posedge clk) disable iff (rst)
        in_valid && op_sel == OP_NEG && opnd_a == '0 |=> res_zero && !res_err);

endmodule

// File: tb/bt_logic_unit_tb.sv
`timescale 1ns/1ps
module bt_logic_unit_tb_top;

    localparam int N = 5;
    localparam int W = 2 * N;
    localparam int RANGE = 243;
    localparam int HALF  = 121;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [2:0]   op_sel;
    logic [W-1:0] opnd_a, opnd_b, opnd_c;
    logic [W-1:0] res_word;
    logic         res_zero;
    logic [1:0]   res_carry;
    logic         res_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    bt_logic_unit #(.N_TRITS(N)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .res_word(res_word), .res_zero(res_zero),
        .res_carry(res_carry), .res_err(res_err)
    );

    function automatic logic [1:0] tcode(int d);
        if (d > 0) return 2'b01;
        if (d < 0) return 2'b11;
        return 2'b00;
    endfunction

    function automatic logic [W-1:0] enc(int v);
        logic [W-1:0] w = '0;
        int x = v;
        for (int k = 0; k < N; k++) begin
            int r = x % 3;
            if (r < 0) r += 3;
            if (r == 2) r = -1;
            w[2*k +: 2] = tcode(r);
            x = (x - r) / 3;
        end
        return w;
    endfunction

    function automatic int dig(logic [W-1:0] w, int k);
        case (w[2*k +: 2])
            2'b01:   return 1;
            2'b11:   return -1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [W-1:0] rep(int d);
        logic [W-1:0] w;
        for (int k = 0; k < N; k++) w[2*k +: 2] = tcode(d);
        return w;
    endfunction

    // expected logic-op word from digit values
    function automatic logic [W-1:0] exp_logic(int op, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        logic [W-1:0] w;
        for (int k = 0; k < N; k++) begin
            int x = dig(a, k), y = dig(b, k), z = dig(c, k);
            int hi = (x > y) ? x : y;
            int lo = (x < y) ? x : y;
            int r;
            if (z > hi) hi = z;
            if (z < lo) lo = z;
            case (op)
                0:       r = -x;
                1:       r = (x < y) ? x : y;
                2:       r = hi;
                default: r = x + y + z - hi - lo;
            endcase
            w[2*k +: 2] = tcode(r);
        end
        return w;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        @(negedge clk);
        in_valid = 1'b1;
        op_sel   = op;
        opnd_a   = a;
        opnd_b   = b;
        opnd_c   = c;
        @(posedge clk);
        #1;
    endtask

    task automatic arith(int op, int av, int bv);
        int tot = (op == 4) ? av + bv : av - bv;
        int cy  = (tot > HALF) ? 1 : ((tot < -HALF) ? -1 : 0);
        int wv  = tot - cy * RANGE;
        run(3'(op), enc(av), enc(bv), '0);
        if (op == 4) begin
            chk("R6 sum word", res_word, enc(wv));
            chk("R6 carry", res_carry, tcode(cy));
        end else begin
            chk("R7 difference word", res_word, enc(wv));
            chk("R7 carry", res_carry, tcode(cy));
        end
        chk("R8 zero flag arith", res_zero, (wv == 0));
    endtask

    task automatic logic_op(int op, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        logic [W-1:0] e = exp_logic(op, a, b, c);
        run(3'(op), a, b, c);
        case (op)
            0:       chk("R2 negate", res_word, e);
            1:       chk("R3 minimum", res_word, e);
            2:       chk("R4 maximum", res_word, e);
            default: chk("R5 median", res_word, e);
        endcase
        chk("R8 zero flag logic", res_zero, (e == '0));
        chk("R6 carry zero on logic op", res_carry, 2'b00);
    endtask

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        op_sel = 3'd0;
        opnd_a = '0;
        opnd_b = '0;
        opnd_c = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R11 reset word", res_word, '0);
        chk("R11 reset zero", res_zero, 1'b0);
        chk("R11 reset carry", res_carry, 2'b00);
        chk("R11 reset err", res_err, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R8 canonical case: (+1) + (-1)
        run(3'd4, enc(1), enc(-1), '0);
        chk("R8 plus one minus one word", res_word, '0);
        chk("R8 plus one minus one zero", res_zero, 1'b1);
        chk("R1 err clear on legal input", res_err, 1'b0);

        // R5 all 27 digit triples, R3/R4 too
        for (int x = -1; x <= 1; x++)
            for (int y = -1; y <= 1; y++)
                for (int z = -1; z <= 1; z++) begin
                    logic_op(3, rep(x), rep(y), rep(z));
                    logic_op(2, rep(x), rep(y), rep(z));
                    logic_op(1, rep(x), rep(y), rep(z));
                end
        run(3'd3, rep(-1), rep(0), rep(1));
        chk("R5 median of -1,0,+1", res_word, rep(0));
        run(3'd3, rep(-1), rep(1), rep(1));
        chk("R5 median of -1,+1,+1", res_word, rep(1));

        // mixed words for every op, R2 over every A value
        for (int i = 0; i < RANGE; i++) begin
            logic [W-1:0] aw = enc(i - HALF);
            logic [W-1:0] bw = enc(((i * 7) % RANGE) - HALF);
            logic [W-1:0] cw = enc(((i * 13 + 5) % RANGE) - HALF);
            logic_op(0, aw, bw, cw);
            logic_op(1, aw, bw, cw);
            logic_op(2, aw, bw, cw);
            logic_op(3, aw, bw, cw);
        end

        // R1 illegal digit code treated as 0 and flagged
        run(3'd4, 10'b00_00_00_00_10, enc(1), '0);
        chk("R1 bad digit as zero", res_word, enc(1));
        chk("R1 bad digit err", res_err, 1'b1);
        run(3'd0, enc(5), '0, 10'b10_00_00_00_00);
        chk("R1 bad C digit err", res_err, 1'b1);
        chk("R1 bad C result", res_word, enc(-5));
        run(3'd3, 10'b10_10_10_10_10, rep(1), rep(-1));
        chk("R1 all-bad median", res_word, '0);
        run(3'd4, enc(7), enc(3), '0);
        chk("R1 err clears on legal input", res_err, 1'b0);

        // R9 undefined operation codes
        for (int op = 6; op <= 7; op++) begin
            run(3'(op), enc(40), enc(-17), enc(3));
            chk("R9 undefined op word", res_word, '0);
            chk("R9 undefined op zero", res_zero, 1'b1);
            chk("R9 undefined op carry", res_carry, 2'b00);
            chk("R9 undefined op err", res_err, 1'b1);
        end

        // R10 hold while strobe low
        run(3'd4, enc(5), enc(7), '0);
        @(negedge clk);
        in_valid = 1'b0;
        op_sel = 3'd6;
        opnd_a = 10'b10_10_10_10_10;
        opnd_b = enc(-60);
        repeat (2) @(posedge clk);
        #1;
        chk("R10 hold word", res_word, enc(12));
        chk("R10 hold err", res_err, 1'b0);
        chk("R10 hold zero", res_zero, 1'b0);

        // R6 / R7 exhaustive over all operand pairs
        for (int av = -HALF; av <= HALF; av++)
            for (int bv = -HALF; bv <= HALF; bv++) begin
                arith(4, av, bv);
                arith(5, av, bv);
            end

        @(negedge clk);
        in_valid = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #950000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule